// File: doc/BRIEF.md
# Multi-Domain Clock Ratio Divider

This block takes a single fast source clock, the output of a fixed-multiplier frequency synthesiser, and produces five clock-enable strobes for the core, bus, peripheral, timer and converter domains. Each strobe is high for one source cycle out of every N, with N chosen per domain from 1, 2, 4 or 8. A sixth enable drives an external clock-out pin and always follows the bus rate. Every strobe comes from one shared free-running phase counter, so the domains stay phase-aligned.

Software writes one ratio register that holds all five 2-bit divisor codes. The block checks each write against the frequency ordering rules that bind the domains. A legal setting is held as pending and applied only when the phase counter wraps to zero, so no domain ever sees a shortened period. An illegal setting is dropped and sets a sticky error flag, which software clears by writing one to it.

Top module: `cdiv_top`

## Requirements
- R1: After a synchronous reset, the ratio register reads 0x2A4 (core 1/1, bus 1/2, peripheral 1/4, timer 1/4, converter 1/4), busy reads 0 and the error flag reads 0.
- R2: Each ratio field is two bits wide, at bits [1:0] core, [3:2] bus, [5:4] peripheral, [7:6] timer and [9:8] converter. Code 00 divides by 1, 01 by 2, 10 by 4 and 11 by 8.
- R3: A 3-bit phase counter starts at 0 in the first cycle after reset and counts up every source cycle. A domain with divisor N strobes exactly in the cycles where the phase is a multiple of N, so every strobe is high when the phase is 0.
- R4: A written setting is legal only if its codes meet all of these: bus >= core, peripheral >= bus, timer >= core and converter <= peripheral. A larger code means a slower clock.
- R5: Because the source runs at its maximum rate, a bus code of 00 or a peripheral code of 00 is illegal.
- R6: A ratio write that breaks any rule in R4 or R5 leaves the active setting and any pending setting unchanged, and sets the error flag. The flag stays set until it is cleared.
- R7: A write to the status address (1) with bit 1 set clears the error flag. A status write with bit 1 clear leaves the flag unchanged.
- R8: A legal ratio write (address 0) becomes pending and busy goes high in the next cycle. The old setting stays active until the phase counter goes from 7 to 0. In the cycle with phase 0 the new setting drives the strobes and the readback, and busy is low.
- R9: The clock-out enable equals the bus strobe in every cycle.
- R10: Reading address 0 returns the active setting. Reading address 1 returns the busy flag in bit 0 and the error flag in bit 1, with zeros above them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Source clock (synthesiser output) |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 1 | Write address: 0 ratio, 1 status |
| wr_data | input | 10 | Write data |
| rd_addr | input | 1 | Read address: 0 ratio, 1 status |
| rd_data | output | 10 | Read data (combinational) |
| core_stb | output | 1 | Core domain clock enable |
| bus_stb | output | 1 | Bus domain clock enable |
| periph_stb | output | 1 | Peripheral domain clock enable |
| timer_stb | output | 1 | Timer domain clock enable |
| conv_stb | output | 1 | Converter domain clock enable |
| clkout_en | output | 1 | External clock-out enable, bus rate |
| busy | output | 1 | A legal setting is waiting for the wrap |
| cfg_err | output | 1 | Sticky illegal-write flag |

## Verification
The bench writes settings at various phases of the counter and checks every cycle up to the wrap. A design that applied a setting at once would show the new strobes before phase 0 and cut a period short. A design that applied it one cycle late would still show the old setting at phase 0. Each ordering rule is broken on its own, including the bus code 00 case that satisfies every relative rule. A checker that missed any one rule would accept that write, and busy would rise instead of the error flag. The error flag is also written with zero to catch a clear that ignores the data bit.

// File: rtl/cdiv_pkg.sv
`timescale 1ns/1ps
package cdiv_pkg;

    parameter int NUM_DOM  = 5;
    parameter int CODE_W   = 2;
    parameter int CNT_W    = 3;
    parameter bit SRC_AT_MAX = 1'b1;

    localparam int CFG_W    = NUM_DOM * CODE_W;
    localparam int DATA_W   = CFG_W;
    localparam int BUSY_BIT = 0;
    localparam int ERR_BIT  = 1;

    typedef logic [CODE_W-1:0] ratio_t;
    typedef logic [CNT_W-1:0]  phase_t;

    typedef struct packed {
        ratio_t conv;
        ratio_t timer;
        ratio_t periph;
        ratio_t bus;
        ratio_t core;
    } ratio_cfg_t;

    typedef struct packed {
        logic bus_fast;
        logic periph_fast;
        logic timer_fast;
        logic conv_slow;
        logic over_max;
    } viol_t;

    typedef enum logic {
        ADDR_RATIO  = 1'b0,
        ADDR_STATUS = 1'b1
    } reg_addr_e;

    localparam ratio_cfg_t CFG_RESET = '{
        conv:   2'd2,
        timer:  2'd2,
        periph: 2'd2,
        bus:    2'd1,
        core:   2'd0
    };

    function automatic viol_t check_cfg(input ratio_cfg_t c);
        viol_t v;
        v.bus_fast    = (c.bus < c.core);
        v.periph_fast = (c.periph < c.bus);
        v.timer_fast  = (c.timer < c.core);
        v.conv_slow   = (c.conv > c.periph);
        v.over_max    = SRC_AT_MAX && ((c.bus == '0) || (c.periph == '0));
        return v;
    endfunction

    function automatic logic strobe_hit(input phase_t ph, input ratio_t code);
        phase_t mask;
        mask = '0;
        for (int i = 0; i < CNT_W; i++) begin
            if (i < int'(code)) mask[i] = 1'b1;
        end
        return (ph & mask) == '0;
    endfunction

endpackage

// File: rtl/cdiv_phase_counter.sv
`timescale 1ns/1ps
module cdiv_phase_counter
    import cdiv_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    output phase_t phase,
    output logic   wrap
);

    phase_t cnt_q;

    always_ff @(posedge clk) begin
        if (rst) cnt_q <= '0;
        else     cnt_q <= cnt_q + 1'b1;
    end

    assign phase = cnt_q;
    assign wrap  = (cnt_q == '1);

endmodule

// File: rtl/cdiv_strobe_gen.sv
`timescale 1ns/1ps
module cdiv_strobe_gen
    import cdiv_pkg::*;
(
    input  phase_t phase,
    input  ratio_t code,
    output logic   stb
);

    always_comb begin
        stb = strobe_hit(phase, code);
    end

endmodule

// File: rtl/cdiv_ctrl_regs.sv
`timescale 1ns/1ps
module cdiv_ctrl_regs
    import cdiv_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              wrap,
    output ratio_cfg_t        active_cfg,
    output logic              busy,
    output logic              cfg_err
);

    ratio_cfg_t active_q;
    ratio_cfg_t pend_cfg_q;
    logic       pend_q;
    logic       err_q;

    ratio_cfg_t new_cfg;
    viol_t      viol;
    logic       cfg_wr;
    logic       stat_wr;
    logic       cfg_ok;

    always_comb begin
        new_cfg = ratio_cfg_t'(wr_data[CFG_W-1:0]);
        viol    = check_cfg(new_cfg);
        cfg_ok  = (viol == '0);
        cfg_wr  = wr_en && (reg_addr_e'(wr_addr) == ADDR_RATIO);
        stat_wr = wr_en && (reg_addr_e'(wr_addr) == ADDR_STATUS);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            active_q   <= CFG_RESET;
            pend_cfg_q <= CFG_RESET;
            pend_q     <= 1'b0;
            err_q      <= 1'b0;
        end else begin
            if (pend_q && wrap) begin
                active_q <= pend_cfg_q;
                pend_q   <= 1'b0;
            end
            if (cfg_wr) begin
                if (cfg_ok) begin
                    pend_cfg_q <= new_cfg;
                    pend_q     <= 1'b1;
                end else begin
                    err_q <= 1'b1;
                end
            end
            if (stat_wr && wr_data[ERR_BIT]) begin
                err_q <= 1'b0;
            end
        end
    end

    assign active_cfg = active_q;
    assign busy       = pend_q;
    assign cfg_err    = err_q;

endmodule

// File: rtl/cdiv_top.sv
`timescale 1ns/1ps
module cdiv_top
    import cdiv_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic              core_stb,
    output logic              bus_stb,
    output logic              periph_stb,
    output logic              timer_stb,
    output logic              conv_stb,
    output logic              clkout_en,
    output logic              busy,
    output logic              cfg_err
);

    phase_t     phase_q;
    logic       wrap;
    ratio_cfg_t active_cfg;
    ratio_t     dom_code [NUM_DOM];
    logic [NUM_DOM-1:0] stb_vec;

    cdiv_phase_counter u_cnt (
        .clk   (clk),
        .rst   (rst),
        .phase (phase_q),
        .wrap  (wrap)
    );

    cdiv_ctrl_regs u_regs (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .wrap       (wrap),
        .active_cfg (active_cfg),
        .busy       (busy),
        .cfg_err    (cfg_err)
    );

    always_comb begin
        dom_code[0] = active_cfg.core;
        dom_code[1] = active_cfg.bus;
        dom_code[2] = active_cfg.periph;
        dom_code[3] = active_cfg.timer;
        dom_code[4] = active_cfg.conv;
    end

    for (genvar g = 0; g < NUM_DOM; g++) begin : g_dom
        cdiv_strobe_gen u_gen (
            .phase (phase_q),
            .code  (dom_code[g]),
            .stb   (stb_vec[g])
        );
    end

    cdiv_strobe_gen u_clkout (
        .phase (phase_q),
        .code  (active_cfg.bus),
        .stb   (clkout_en)
    );

    assign core_stb   = stb_vec[0];
    assign bus_stb    = stb_vec[1];
    assign periph_stb = stb_vec[2];
    assign timer_stb  = stb_vec[3];
    assign conv_stb   = stb_vec[4];

    always_comb begin
        rd_data = '0;
        case (reg_addr_e'(rd_addr))
            ADDR_RATIO:  rd_data = active_cfg;
            ADDR_STATUS: begin
                rd_data[BUSY_BIT] = busy;
                rd_data[ERR_BIT]  = cfg_err;
            end
            default:     rd_data = '0;
        endcase
    end

endmodule

// File: rtl/cdiv_checker.sv
`timescale 1ns/1ps
module cdiv_checker
    import cdiv_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              wr_en,
    input logic              wr_addr,
    input logic [DATA_W-1:0] wr_data,
    input phase_t            phase,
    input logic              wrap,
    input ratio_cfg_t        active_cfg,
    input logic              core_stb,
    input logic              bus_stb,
    input logic              periph_stb,
    input logic              timer_stb,
    input logic              conv_stb,
    input logic              clkout_en,
    input logic              busy,
    input logic              cfg_err
);

    AST_ALL_AT_ZERO: assert property (@(posedge clk) disable iff (rst)
        (phase == '0) |-> (core_stb && bus_stb && periph_stb && timer_stb && conv_stb)); // R3

    AST_BUS_WITHIN_CORE: assert property (@(posedge clk) disable iff (rst)
        bus_stb |-> core_stb); // R4

    AST_PERIPH_WITHIN_BUS: assert property (@(posedge clk) disable iff (rst)
        periph_stb |-> bus_stb); // R4

    AST_TIMER_WITHIN_CORE: assert property (@(posedge clk) disable iff (rst)
        timer_stb |-> core_stb); // R4

    AST_CONV_COVERS_PERIPH: assert property (@(posedge clk) disable iff (rst)
        periph_stb |-> conv_stb); // R4

    AST_NO_FULL_RATE: assert property (@(posedge clk) disable iff (rst)
        (active_cfg.bus != '0) && (active_cfg.periph != '0)); // R5

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
        (cfg_err && !(wr_en && wr_addr && wr_data[ERR_BIT])) |=> cfg_err); // R6

    AST_ERR_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr && wr_data[ERR_BIT]) |=> !cfg_err); // R7

    AST_HOLD_UNTIL_WRAP: assert property (@(posedge clk) disable iff (rst)
        !wrap |=> $stable(active_cfg)); // R8

    AST_BUSY_DROPS: assert property (@(posedge clk) disable iff (rst)
        (busy && wrap && !wr_en) |=> !busy); // R8

    AST_CLKOUT_MIRROR: assert property (@(posedge clk) disable iff (rst)
        clkout_en == bus_stb); // R9

endmodule

bind cdiv_top cdiv_checker u_chk (
    .clk        (clk),
    .rst        (rst),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data),
    .phase      (phase_q),
    .wrap       (wrap),
    .active_cfg (active_cfg),
    .core_stb   (core_stb),
    .bus_stb    (bus_stb),
    .periph_stb (periph_stb),
    .timer_stb  (timer_stb),
    .conv_stb   (conv_stb),
    .clkout_en  (clkout_en),
    .busy       (busy),
    .cfg_err    (cfg_err)
);

// File: tb/cdiv_top_tb_top.sv
`timescale 1ns/1ps
module cdiv_top_tb_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic       wr_addr = 1'b0;
    logic [9:0] wr_data = '0;
    logic       rd_addr = 1'b0;
    logic [9:0] rd_data;
    logic core_stb, bus_stb, periph_stb, timer_stb, conv_stb, clkout_en, busy, cfg_err;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    int mph = 0;   // bench phase model (R3)

    always #10 clk = ~clk;

    always @(posedge clk) begin
        if (rst) mph <= 0;
        else     mph <= (mph + 1) % 8;
    end

    cdiv_top dut_i (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data),
        .core_stb(core_stb), .bus_stb(bus_stb), .periph_stb(periph_stb),
        .timer_stb(timer_stb), .conv_stb(conv_stb), .clkout_en(clkout_en),
        .busy(busy), .cfg_err(cfg_err)
    );

    function automatic logic [9:0] mk(int c, int b, int p, int t, int v);
        return 10'((v << 8) | (t << 6) | (p << 4) | (b << 2) | c);
    endfunction

    function automatic bit hit(int ph, logic [9:0] cfg, int fld);
        int code = int'((cfg >> (2 * fld)) & 10'h3);
        return (ph % (1 << code)) == 0;
    endfunction

    task automatic chk(bit ok, string req, string what, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
        end
    endtask

    task automatic rd(logic a, output logic [9:0] d);
        rd_addr = a;
        #1;
        d = rd_data;
    endtask

    task automatic wr(logic a, logic [9:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; wr_data = '0;
    endtask

    task automatic chk_strobes(logic [9:0] cfg, string req);
        logic [5:0] act, exp;
        act = {clkout_en, conv_stb, timer_stb, periph_stb, bus_stb, core_stb};
        exp = {hit(mph, cfg, 1), hit(mph, cfg, 4), hit(mph, cfg, 3),
               hit(mph, cfg, 2), hit(mph, cfg, 1), hit(mph, cfg, 0)};
        chk(act == exp, req, $sformatf("strobes phase %0d", mph), int'(act), int'(exp));
    endtask

    // Legal write, checks hold-off until wrap then new setting (R2 R3 R8 R9 R10)
    task automatic t_apply(logic [9:0] old_cfg, logic [9:0] new_cfg, int run);
        logic [9:0] d;
        wr(1'b0, new_cfg);
        do begin
            chk(busy === 1'b1, "R8", "busy while pending", int'(busy), 1);
            rd(1'b0, d);
            chk(d === old_cfg, "R8", "old setting held", int'(d), int'(old_cfg));
            chk_strobes(old_cfg, "R8");
            @(negedge clk);
        end while (mph != 0);
        chk(busy === 1'b0, "R8", "busy after wrap", int'(busy), 0);
        rd(1'b0, d);
        chk(d === new_cfg, "R10", "readback new setting", int'(d), int'(new_cfg));
        for (int i = 0; i < run; i++) begin
            chk_strobes(new_cfg, "R2 R3 R9");
            @(negedge clk);
        end
    endtask

    // Illegal write: rejected, error set (R4 R5 R6)
    task automatic t_reject(logic [9:0] cur_cfg, logic [9:0] bad, string req);
        logic [9:0] d;
        wr(1'b1, 10'h002);
        chk(cfg_err === 1'b0, "R7", "error cleared", int'(cfg_err), 0);
        wr(1'b0, bad);
        chk(cfg_err === 1'b1, req, "error set on illegal", int'(cfg_err), 1);
        chk(busy === 1'b0, "R6", "no pending after illegal", int'(busy), 0);
        for (int i = 0; i < 10; i++) begin
            chk_strobes(cur_cfg, "R6");
            @(negedge clk);
        end
        rd(1'b0, d);
        chk(d === cur_cfg, "R6", "active unchanged", int'(d), int'(cur_cfg));
        chk(cfg_err === 1'b1, "R6", "error sticky", int'(cfg_err), 1);
    endtask

    task automatic t_reset();
        logic [9:0] d;
        rd(1'b0, d);
        chk(d === 10'h2A4, "R1", "reset ratio", int'(d), 'h2A4);
        rd(1'b1, d);
        chk(d === 10'h000, "R1", "reset status", int'(d), 0);
        for (int i = 0; i < 9; i++) begin
            chk_strobes(10'h2A4, "R1 R3");
            @(negedge clk);
        end
    endtask

    task automatic t_err_clear();
        logic [9:0] d;
        wr(1'b0, mk(1, 0, 1, 1, 1));
        chk(cfg_err === 1'b1, "R5", "error set", int'(cfg_err), 1);
        rd(1'b1, d);
        chk(d === 10'h002, "R10", "status shows error", int'(d), 2);
        wr(1'b1, 10'h3FD);
        chk(cfg_err === 1'b1, "R7", "status write bit1=0 keeps error", int'(cfg_err), 1);
        wr(1'b1, 10'h002);
        chk(cfg_err === 1'b0, "R7", "status write bit1=1 clears", int'(cfg_err), 0);
    endtask

    initial begin
        logic [9:0] c0, c1, c2, c3, c4;
        c0 = mk(0, 1, 1, 0, 0);
        c1 = mk(0, 1, 2, 3, 1);
        c2 = mk(1, 1, 3, 1, 3);
        c3 = mk(2, 2, 3, 3, 2);
        c4 = mk(0, 2, 3, 0, 0);
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_apply(10'h2A4, c0, 16);
        t_apply(c0, c1, 16);
        @(negedge clk);
        t_apply(c1, c2, 16);
        repeat (3) @(negedge clk);
        t_apply(c2, c3, 16);
        repeat (5) @(negedge clk);
        t_apply(c3, c4, 16);
        t_reject(c4, mk(2, 1, 2, 2, 2), "R4");   // bus faster than core
        t_reject(c4, mk(0, 2, 1, 0, 0), "R4");   // peripheral faster than bus
        t_reject(c4, mk(2, 2, 2, 1, 2), "R4");   // timer faster than core
        t_reject(c4, mk(0, 1, 1, 0, 2), "R4");   // converter slower than peripheral
        t_reject(c4, mk(0, 0, 1, 0, 0), "R5");   // bus at full source rate
        t_err_clear();
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule